// File: doc/BRIEF.md
# Timer Event Status and Interrupt Controller

This block gathers seven event sources of a low-power timer into one read-only status word and drives a single interrupt/wake-up line. Two of the events come from equality comparators inside the block. One comparator checks the running counter value against the compare value, the other checks it against the reload value. The remaining five events arrive as single-cycle pulses from neighbouring logic: an external trigger, completion of a compare-value write, completion of a reload-value write, and the two direction-change indications of the encoder front end.

Software reaches the block through a small register port. It can read the status word, clear chosen flags by writing ones, and program an enable mask. A two-bit field selects which direction changes are reported. The interrupt is armed per flag. It rises only when a flag is set by an event while that flag's enable is already on. Turning on the enable of a flag that is already pending does not raise the line.

Top module: `tis_irq_status`

## Requirements
- R1: Offset 0x0 reads the status flags in bits 6:0 with the layout compare match (bit 0), reload match (bit 1), external trigger (bit 2), compare write done (bit 3), reload write done (bit 4), up change (bit 5) and down change (bit 6). Bits 31:7 read zero. After reset the word is zero, and writes to offset 0x0 have no effect.
- R2: Bit 0 sets on the first cycle in which the counter equals the compare value. Holding the counter at that value does not detect the match again.
- R3: Bit 1 sets on the first cycle in which the counter equals the reload value. Holding the counter at that value does not detect the match again.
- R4: A pulse on the external trigger, compare-write-done or reload-write-done input sets bit 2, 3 or 4 respectively.
- R5: Direction pulses pass through the report selector: 2'b01 reports only up changes (bit 5), 2'b10 reports only down changes (bit 6), 2'b11 reports both and 2'b00 reports neither.
- R6: Writing to offset 0x4 clears every status flag whose data bit is 1 and leaves the other flags unchanged. Offset 0x4 reads zero.
- R7: When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R8: Offset 0x8 is the enable mask, read/write in bits 6:0, with the same layout as the status word. It resets to zero.
- R9: The interrupt output is registered. It rises at the same clock edge as a flag whose event occurred while that flag's enable was already set. The enable value in force before a write in the same cycle is the one that counts.
- R10: Setting an enable bit whose flag is already set does not raise the interrupt.
- R11: The interrupt stays high until every armed flag is cleared or has had its enable bit removed. It then falls at the clock edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Running counter value |
| cmp_val_i | input | CNT_W | Compare value |
| rld_val_i | input | CNT_W | Reload value |
| ext_trig_i | input | 1 | External trigger pulse |
| cmp_wdone_i | input | 1 | Compare-write-complete pulse |
| rld_wdone_i | input | 1 | Reload-write-complete pulse |
| dir_up_i | input | 1 | Change-to-up pulse |
| dir_dn_i | input | 1 | Change-to-down pulse |
| dir_sel_i | input | 2 | Direction report selector |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt / wake-up level |

## Verification
The bench builds the block with CNT_W = 8 and ADDR_W = 4. With the narrow counter, both the all-ones compare value and a reload match on the same value as a compare match can be reached in a few cycles. With four address bits, the three mapped offsets and an unmapped one can all be used. A cycle-level reference model in the bench predicts the read data and the interrupt level. This exercises held-counter non-redetection, event-versus-clear collisions, and enable writes that coincide with events.

// File: rtl/tis_pkg.sv
package tis_pkg;

  localparam int NUM_EV = 7;

  localparam int EV_CMP   = 0;
  localparam int EV_RLD   = 1;
  localparam int EV_EXT   = 2;
  localparam int EV_CMPWD = 3;
  localparam int EV_RLDWD = 4;
  localparam int EV_UP    = 5;
  localparam int EV_DN    = 6;

  localparam int OFF_STATUS = 'h0;
  localparam int OFF_CLEAR  = 'h4;
  localparam int OFF_ENABLE = 'h8;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // Rising edge of an equality condition.
  function automatic logic first_hit(input logic now_eq, input logic prev_eq);
    return now_eq & ~prev_eq;
  endfunction

  // Direction report gating: sel[0] passes up, sel[1] passes down.
  function automatic logic [1:0] dir_gate(input logic up, input logic dn,
                                          input logic [1:0] sel);
    return {dn & sel[1], up & sel[0]};
  endfunction

  // Zero-extend a flag vector to a 32-bit register word.
  function automatic logic [31:0] widen(input ev_vec_t v);
    return {{(32-NUM_EV){1'b0}}, v};
  endfunction

  // Next state of one flag: a new event beats a clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

endpackage

// File: rtl/tis_match_detect.sv
module tis_match_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ref_i,
  output logic         eq_o,
  output logic         hit_o
);
  import tis_pkg::*;

  logic eq_q;

  assign eq_o  = (cnt_i == ref_i);
  assign hit_o = first_hit(eq_o, eq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_o;
  end
endmodule

// File: rtl/tis_flag_bank.sv
module tis_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_cur_i,
  input  logic [N-1:0] en_nxt_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] armed_o,
  output logic [N-1:0] armed_nxt_o
);
  import tis_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic flag_q, armed_q;

    assign armed_nxt_o[i] = ((armed_q & ~clr_i[i]) | (ev_i[i] & en_cur_i[i])) & en_nxt_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        flag_q  <= flag_next(flag_q, clr_i[i], ev_i[i]);
        armed_q <= armed_nxt_o[i];
      end
    end

    assign flags_o[i] = flag_q;
    assign armed_o[i] = armed_q;
  end
endmodule

// File: rtl/tis_irq_status.sv
module tis_irq_status #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  input  logic [CNT_W-1:0]  rld_val_i,
  input  logic              ext_trig_i,
  input  logic              cmp_wdone_i,
  input  logic              rld_wdone_i,
  input  logic              dir_up_i,
  input  logic              dir_dn_i,
  input  logic [1:0]        dir_sel_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  import tis_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);

  // Named internal events, visible to the checker.
  logic    cmp_eq, rld_eq, cmp_hit, rld_hit;
  logic [1:0] dir_ev;
  ev_vec_t ev_all, clr_vec, en_q, en_nxt, flags, armed, armed_nxt;
  logic    clr_wr, en_wr;

  tis_match_detect #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ref_i(cmp_val_i),
    .eq_o(cmp_eq), .hit_o(cmp_hit)
  );

  tis_match_detect #(.W(CNT_W)) u_rld (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ref_i(rld_val_i),
    .eq_o(rld_eq), .hit_o(rld_hit)
  );

  assign dir_ev = dir_gate(dir_up_i, dir_dn_i, dir_sel_i);

  always_comb begin
    ev_all           = '0;
    ev_all[EV_CMP]   = cmp_hit;
    ev_all[EV_RLD]   = rld_hit;
    ev_all[EV_EXT]   = ext_trig_i;
    ev_all[EV_CMPWD] = cmp_wdone_i;
    ev_all[EV_RLDWD] = rld_wdone_i;
    ev_all[EV_UP]    = dir_ev[0];
    ev_all[EV_DN]    = dir_ev[1];
  end

  assign clr_wr  = reg_wr_i && (reg_addr_i == A_CLEAR);
  assign en_wr   = reg_wr_i && (reg_addr_i == A_ENABLE);
  assign clr_vec = clr_wr ? reg_wdata_i[NUM_EV-1:0] : '0;
  assign en_nxt  = en_wr  ? reg_wdata_i[NUM_EV-1:0] : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  tis_flag_bank #(.N(NUM_EV)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_all), .clr_i(clr_vec),
    .en_cur_i(en_q), .en_nxt_i(en_nxt),
    .flags_o(flags), .armed_o(armed), .armed_nxt_o(armed_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |armed_nxt;
  end

  always_comb begin
    case (reg_addr_i)
      A_STATUS: reg_rdata_o = widen(flags);
      A_ENABLE: reg_rdata_o = widen(en_q);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tis_irq_status_checker.sv
module tis_irq_status_checker (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmp_eq,
  input logic                 rld_eq,
  input tis_pkg::ev_vec_t     ev_all,
  input tis_pkg::ev_vec_t     flags,
  input tis_pkg::ev_vec_t     en_q,
  input logic [1:0]           dir_sel_i,
  input logic [31:0]          reg_rdata_o,
  input logic                 irq_o
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[31:7] == '0);

  assert_no_redetect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmp_eq)) |-> !ev_all[0]);

  assert_no_redetect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rld_eq)) |-> !ev_all[1]);

  assert_dir_gate_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_all[5] |-> dir_sel_i[0]);

  assert_dir_gate_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_all[6] |-> dir_sel_i[1]);

  assert_flag_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(ev_all)) == '0));

  assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & $past(ev_all)) == $past(ev_all)));

  assert_irq_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(ev_all & en_q) != '0));

  assert_irq_backed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flags & en_q) != '0));
endmodule

bind tis_irq_status tis_irq_status_checker chk (
  .clk(clk), .rst_n(rst_n), .cmp_eq(cmp_eq), .rld_eq(rld_eq),
  .ev_all(ev_all), .flags(flags), .en_q(en_q), .dir_sel_i(dir_sel_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
);

// File: tb/tis_irq_status_test.sv
`timescale 1ns/1ps
module tis_irq_status_test;
  localparam int CW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt = 8'd1, cmpv = 8'd5, rldv = 8'd9;
  logic ext = 0, cwd = 0, rwd = 0, up = 0, dn = 0;
  logic [1:0] sel = 2'b00;
  logic [AW-1:0] addr = '0;
  logic wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #10 clk = ~clk;

  tis_irq_status #(.CNT_W(CW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cmp_val_i(cmpv), .rld_val_i(rldv),
    .ext_trig_i(ext), .cmp_wdone_i(cwd), .rld_wdone_i(rwd),
    .dir_up_i(up), .dir_dn_i(dn), .dir_sel_i(sel),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t q[$];

  int nchk = 0, nerr = 0;

  // Reference state built from the requirements.
  logic [6:0] m_flags = '0, m_en = '0, m_armed = '0;
  logic m_pc = 0, m_pr = 0;

  task automatic check(input string tag, input logic [31:0] grd, input logic [31:0] erd,
                       input logic girq, input logic eirq);
    nchk++;
    if (grd !== erd || girq !== eirq) begin
      nerr++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, grd, girq, erd, eirq);
    end
  endtask

  // Driver: predicts the post-edge state from current inputs, queues it, advances a cycle.
  task automatic tick(input string tag);
    logic [6:0] ev, clr, en_n, fl_n, ar_n;
    logic ec, er;
    exp_t e;
    ec = (cnt == cmpv); er = (cnt == rldv);
    ev = {dn & sel[1], up & sel[0], rwd, cwd, ext, er & ~m_pr, ec & ~m_pc};
    clr  = (wr && addr == 4'h4) ? wdata[6:0] : 7'h0;
    en_n = (wr && addr == 4'h8) ? wdata[6:0] : m_en;
    fl_n = (m_flags & ~clr) | ev;
    ar_n = ((m_armed & ~clr) | (ev & m_en)) & en_n;
    m_pc = ec; m_pr = er; m_flags = fl_n; m_en = en_n; m_armed = ar_n;
    e.rd  = (addr == 4'h0) ? {25'h0, fl_n} : (addr == 4'h8) ? {25'h0, en_n} : 32'h0;
    e.irq = |ar_n;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle();
    ext = 0; cwd = 0; rwd = 0; up = 0; dn = 0; wr = 0; addr = 4'h0; wdata = '0;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d, input string tag);
    addr = a; wr = 1; wdata = d;
    tick(tag);
    idle();
  endtask

  // Monitor: pops one expectation per clock edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, rdata, e.rd, irq, e.irq);
    end
  end

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", rdata, 32'h0, irq, 1'b0);
    rst_n = 1;
    tick("R1 idle after reset");

    // R2: compare match once, not re-detected while held
    cnt = 8'd5; tick("R2 compare hit");
    tick("R2 held value");
    reg_write(4'h4, 32'h1, "R6 clear bit0");
    tick("R2 no redetect after clear");

    // R3: reload match
    cnt = 8'd9; tick("R3 reload hit");
    tick("R3 held value");
    reg_write(4'h4, 32'h2, "R6 clear bit1");
    tick("R3 no redetect after clear");

    // R4: pulses
    ext = 1; tick("R4 ext trigger"); idle();
    cwd = 1; tick("R4 compare write done"); idle();
    rwd = 1; tick("R4 reload write done"); idle();

    // R5: direction selector
    sel = 2'b00; up = 1; dn = 1; tick("R5 sel none"); idle();
    sel = 2'b01; up = 1; dn = 1; tick("R5 sel up"); idle();
    reg_write(4'h4, 32'h20, "R6 clear up");
    sel = 2'b10; up = 1; dn = 1; tick("R5 sel down"); idle();
    reg_write(4'h4, 32'h40, "R6 clear down");
    sel = 2'b11; up = 1; tick("R5 both up"); idle();
    dn = 1; tick("R5 both down"); idle();

    // R1: status write ignored, unmapped offset reads zero
    reg_write(4'h0, 32'hFFFF_FFFF, "R1 status write ignored");
    tick("R1 status after write");
    addr = 4'hC; tick("R1 unmapped reads zero"); idle();
    reg_write(4'h4, 32'hFFFF_FFFF, "R6 clear all");
    tick("R6 all cleared");

    // R8 / R9: enable then event
    reg_write(4'h8, 32'hFFFF_FF81, "R8 enable write");
    addr = 4'h8; tick("R8 enable readback"); idle();
    cnt = 8'd1; tick("R9 leave match");
    cnt = 8'd5; tick("R9 armed compare raises irq");
    tick("R11 irq held");
    reg_write(4'h4, 32'h1, "R11 clear drops irq");
    tick("R11 irq low");

    // R10: enable after flag already set
    ext = 1; tick("R10 ext without enable"); idle();
    reg_write(4'h8, 32'h05, "R10 enable pending flag");
    tick("R10 irq stays low");

    // R7: event and clear same cycle
    ext = 1; addr = 4'h4; wr = 1; wdata = 32'h4; tick("R7 event beats clear"); idle();
    tick("R7 flag still set with irq");
    reg_write(4'h4, 32'h4, "R11 clear ext");

    // R9: enable write in the same cycle as event uses old enable
    reg_write(4'h8, 32'h0, "R8 disable all");
    rwd = 1; addr = 4'h8; wr = 1; wdata = 32'h10; tick("R9 same-cycle enable not armed"); idle();
    tick("R9 irq low");
    reg_write(4'h4, 32'h10, "R6 clear rld done");

    // R11: removing enable drops irq
    cwd = 1; tick("R11 prep no irq"); idle();
    reg_write(4'h8, 32'h08, "R8 enable bit3");
    reg_write(4'h4, 32'h08, "R6 clear bit3");
    cwd = 1; tick("R9 armed write done"); idle();
    reg_write(4'h8, 32'h0, "R11 disable drops irq");
    reg_write(4'h8, 32'h08, "R11 re-enable no irq");
    reg_write(4'h4, 32'h7F, "R6 clear all again");

    // R2 boundary: all-ones compare, shared with reload
    cmpv = 8'hFF; rldv = 8'hFF; cnt = 8'hFE; tick("R2 approach ff");
    cnt = 8'hFF; tick("R2 R3 both hit at ff");
    tick("R2 R3 held at ff");

    wait (q.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule